// File: doc/BRIEF.md
# Power-Fail Interrupt Control Registers

This block holds a small set of byte-wide system control registers behind a simple strobe bus: a configuration byte, two auxiliary bytes, a diagnostics byte and a modem-control byte. Alongside them sit a write-only power-management location and a 32-bit system-control register. A register is selected by comparing the bus address, masked with `0x0fff0000`, against a fixed location. Any address bit outside that mask is ignored, so every register is repeated across the address space.

The second auxiliary byte combines software-written bits with a power-fail status bit that only hardware sets. A change on the external power-failing input sets that status when the interrupt enable in the configuration byte is on, and clears it in every other case. Software can clear the status by writing one to a clear bit. The level interrupt output is high while the status and the enable are both set. Three one-cycle request pulses are produced for the system around the block: shutdown, reset and CPU halt.

Top module: `pwrfail_ctl_regs`

## Requirements
- R1: After a synchronous active-high reset, every stored register reads zero, and the interrupt and the three request pulses are low.
- R2: Register locations, after masking with `0x0fff0000`: configuration `0x01800000`, auxiliary A `0x01900000`, diagnostics `0x01a00000`, modem `0x01b00000`. Writes to these locations store the 8 write-data bits, and a later read returns that byte zero-extended to 32 bits. A read presents data on `bus_rdata` in the cycle after the read strobe.
- R3: A read of an unmapped address returns zero. A write to an unmapped address changes no register.
- R4: Every change on `pwr_failing` updates the power-fail status, which reads back as bit 5 (`0x20`) of auxiliary B (`0x01910000`). The status is set when the input is high and configuration bit 3 (`0x08`) is set, and cleared otherwise.
- R5: `pf_irq` is high exactly when the power-fail status and configuration bit 3 are both set. It follows configuration writes without a new input change.
- R6: A write to auxiliary B stores only write-data bit 0 and keeps the power-fail status. If write-data bit 1 (`0x02`) is set, the status is cleared instead of kept. All other written bits are dropped.
- R7: A write to auxiliary B that stores bit 0 (power-off) raises `shutdown_req` for exactly one cycle, in the cycle after the write.
- R8: A write to the power-management location `0x0a000000` raises `halt_req` for one cycle after the write and stores nothing. Reading that location returns zero.
- R9: A write to system control (`0x01f00000`) with data bit 0 set loads the register with `0x00000002` and raises `reset_req` for one cycle. A write with bit 0 clear leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| pwr_failing | input | 1 | External power-failing indication |
| pf_irq | output | 1 | Level power-fail interrupt |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle system reset request |
| halt_req | output | 1 | One-cycle CPU halt request |

## Verification
The power-fail path is driven with the input rising and falling, once with the enable on and once with it off. This separates setting the status on a change from simply copying the input level. The enable is then toggled while the status is held, which shows that the interrupt is gated by the enable rather than latched with the status. Auxiliary B is written with the clear bit, the power-off bit, both together and a byte holding only dropped bits, which isolates the merge of the status from the clear. Aliased and unmapped addresses are checked with distinct byte patterns, so that any decode overlap shows up as a wrong readback.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   // Address decode: only the bits under the mask pick a register.
   localparam logic [31:0] PFC_SEL_MASK = 32'h0fff_0000;
   localparam logic [31:0] ADR_CONFIG   = 32'h0180_0000;
   localparam logic [31:0] ADR_AUX_A    = 32'h0190_0000;
   localparam logic [31:0] ADR_AUX_B    = 32'h0191_0000;
   localparam logic [31:0] ADR_DIAG     = 32'h01a0_0000;
   localparam logic [31:0] ADR_MODEM    = 32'h01b0_0000;
   localparam logic [31:0] ADR_SYSCTL   = 32'h01f0_0000;
   localparam logic [31:0] ADR_PWRMGT   = 32'h0a00_0000;

   // Bit positions that other logic decodes.
   localparam int AUXB_OFF_BIT = 0;
   localparam int AUXB_CLR_BIT = 1;
   localparam int AUXB_PF_BIT  = 5;
   localparam int CFG_PFEN_BIT = 3;
   localparam int SYS_REQ_BIT  = 0;
   localparam int SYS_STAT_BIT = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CFG,
      SEL_AUXA,
      SEL_AUXB,
      SEL_DIAG,
      SEL_MODEM,
      SEL_PWRMGT,
      SEL_SYSCTL
   } pfc_sel_e;

   // Plain byte registers, index 0 must stay the configuration byte.
   localparam int N_PLAIN = 4;

   function automatic pfc_sel_e plain_sel(input int idx);
      case (idx)
         0:       return SEL_CFG;
         1:       return SEL_AUXA;
         2:       return SEL_DIAG;
         default: return SEL_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/pfc_decode.sv
module pfc_decode
   import pfc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output pfc_sel_e          sel
);

   localparam logic [ADDR_W-1:0] MASK = ADDR_W'(PFC_SEL_MASK);

   generate
      if (ADDR_W < 28 || ADDR_W > 32) begin : g_bad_width
         $error("pfc_decode: ADDR_W must be 28..32");
      end
   endgenerate

   logic [ADDR_W-1:0] masked;

   always_comb begin
      masked = addr & MASK;
      if      (masked == ADDR_W'(ADR_CONFIG)) sel = SEL_CFG;
      else if (masked == ADDR_W'(ADR_AUX_A))  sel = SEL_AUXA;
      else if (masked == ADDR_W'(ADR_AUX_B))  sel = SEL_AUXB;
      else if (masked == ADDR_W'(ADR_DIAG))   sel = SEL_DIAG;
      else if (masked == ADDR_W'(ADR_MODEM))  sel = SEL_MODEM;
      else if (masked == ADDR_W'(ADR_SYSCTL)) sel = SEL_SYSCTL;
      else if (masked == ADDR_W'(ADR_PWRMGT)) sel = SEL_PWRMGT;
      else                                    sel = SEL_NONE;
   end

endmodule

// File: rtl/pfc_byte_reg.sv
module pfc_byte_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= d;
   end

endmodule

// File: rtl/pfc_pwrfail.sv
module pfc_pwrfail
   import pfc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_aux,
   input  logic [1:0]        wr_bits,
   input  logic              pwr_failing,
   input  logic              cfg_en,
   output logic [BYTE_W-1:0] aux_q,
   output logic              irq,
   output logic              shutdown_req
);

   generate
      if (BYTE_W <= AUXB_PF_BIT) begin : g_bad_width
         $error("pfc_pwrfail: BYTE_W too small for the status bit");
      end
   endgenerate

   logic pf_q, off_q, prev_q;
   logic pf_n, off_n, pf_evt;

   assign pf_evt = pwr_failing ^ prev_q;

   always_comb begin
      pf_n  = pf_q;
      off_n = off_q;
      if (wr_aux) begin
         off_n = wr_bits[AUXB_OFF_BIT];
         if (wr_bits[AUXB_CLR_BIT]) pf_n = 1'b0;
      end
      // An input change decides the status bit over a same-cycle write.
      if (pf_evt) pf_n = pwr_failing && cfg_en;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pf_q         <= 1'b0;
         off_q        <= 1'b0;
         prev_q       <= 1'b0;
         shutdown_req <= 1'b0;
      end else begin
         pf_q         <= pf_n;
         off_q        <= off_n;
         prev_q       <= pwr_failing;
         shutdown_req <= wr_aux && wr_bits[AUXB_OFF_BIT];
      end
   end

   always_comb begin
      aux_q               = '0;
      aux_q[AUXB_OFF_BIT] = off_q;
      aux_q[AUXB_PF_BIT]  = pf_q;
   end

   assign irq = pf_q && cfg_en;

   // R4: the status only rises when the enable was on at the event.
   assert_pf_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(pf_q) |-> $past(cfg_en));

   // R6: a clear write without a competing input change leaves status low.
   assert_clr_drops_pf_R6: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_aux) && $past(wr_bits[AUXB_CLR_BIT]) && !$past(pf_evt)) |-> !pf_q);

endmodule

// File: rtl/pfc_sysctl.sv
module pfc_sysctl
   import pfc_pkg::*;
#(
   parameter int SYS_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set_req,
   output logic [SYS_W-1:0] q,
   output logic             reset_req
);

   localparam logic [SYS_W-1:0] STAT_VAL = SYS_W'(1) << SYS_STAT_BIT;

   always_ff @(posedge clk) begin
      if (rst) begin
         q         <= '0;
         reset_req <= 1'b0;
      end else begin
         if (set_req) q <= STAT_VAL;
         reset_req <= set_req;
      end
   end

endmodule

// File: rtl/pwrfail_ctl_regs.sv
module pwrfail_ctl_regs
   import pfc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BYTE_W = 8,
   parameter int SYS_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [SYS_W-1:0]  bus_rdata,
   input  logic              pwr_failing,
   output logic              pf_irq,
   output logic              shutdown_req,
   output logic              reset_req,
   output logic              halt_req
);

   generate
      if (BYTE_W != 8 || SYS_W < BYTE_W) begin : g_bad_width
         $error("pwrfail_ctl_regs: BYTE_W must be 8 and SYS_W >= BYTE_W");
      end
   endgenerate

   pfc_sel_e sel;

   pfc_decode #(.ADDR_W(ADDR_W)) decode_i (
      .addr (bus_addr),
      .sel  (sel)
   );

   logic [BYTE_W-1:0] plain_q [N_PLAIN];

   for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
      pfc_byte_reg #(.W(BYTE_W)) reg_i (
         .clk (clk),
         .rst (rst),
         .we  (bus_wr && (sel == plain_sel(gi))),
         .d   (bus_wdata),
         .q   (plain_q[gi])
      );
   end

   logic [BYTE_W-1:0] aux_b_q;

   pfc_pwrfail #(.BYTE_W(BYTE_W)) pwrfail_i (
      .clk          (clk),
      .rst          (rst),
      .wr_aux       (bus_wr && (sel == SEL_AUXB)),
      .wr_bits      (bus_wdata[1:0]),
      .pwr_failing  (pwr_failing),
      .cfg_en       (plain_q[0][CFG_PFEN_BIT]),
      .aux_q        (aux_b_q),
      .irq          (pf_irq),
      .shutdown_req (shutdown_req)
   );

   logic [SYS_W-1:0] sys_q;

   pfc_sysctl #(.SYS_W(SYS_W)) sysctl_i (
      .clk       (clk),
      .rst       (rst),
      .set_req   (bus_wr && (sel == SEL_SYSCTL) && bus_wdata[SYS_REQ_BIT]),
      .q         (sys_q),
      .reset_req (reset_req)
   );

   logic [SYS_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_CFG:    rd_mux = SYS_W'(plain_q[0]);
         SEL_AUXA:   rd_mux = SYS_W'(plain_q[1]);
         SEL_DIAG:   rd_mux = SYS_W'(plain_q[2]);
         SEL_MODEM:  rd_mux = SYS_W'(plain_q[3]);
         SEL_AUXB:   rd_mux = SYS_W'(aux_b_q);
         SEL_SYSCTL: rd_mux = sys_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_rdata <= '0;
         halt_req  <= 1'b0;
      end else begin
         bus_rdata <= bus_rd ? rd_mux : '0;
         halt_req  <= bus_wr && (sel == SEL_PWRMGT);
      end
   end

   // R5: no interrupt while the configuration enable is off.
   assert_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
      pf_irq |-> plain_q[0][CFG_PFEN_BIT]);

   // R7: a shutdown pulse always comes with power-off stored.
   assert_shutdown_off_R7: assert property (@(posedge clk) disable iff (rst)
      shutdown_req |-> aux_b_q[AUXB_OFF_BIT]);

   // R8: a halt pulse only follows a power-management write.
   assert_halt_src_R8: assert property (@(posedge clk) disable iff (rst)
      halt_req |-> ($past(bus_wr) && $past(sel) == SEL_PWRMGT));

   // R9: a reset pulse comes with the status value loaded.
   assert_reset_stat_R9: assert property (@(posedge clk) disable iff (rst)
      reset_req |-> (sys_q == (SYS_W'(1) << SYS_STAT_BIT)));

   // R3: an unmapped read returns zero.
   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_rd) && $past(sel) == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/pwrfail_ctl_regs_tb_top.sv
module pwrfail_ctl_regs_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   localparam logic [31:0] A_CFG  = 32'h0180_0000;
   localparam logic [31:0] A_AUXA = 32'h0190_0000;
   localparam logic [31:0] A_AUXB = 32'h0191_0000;
   localparam logic [31:0] A_DIAG = 32'h01a0_0000;
   localparam logic [31:0] A_MDM  = 32'h01b0_0000;
   localparam logic [31:0] A_SYS  = 32'h01f0_0000;
   localparam logic [31:0] A_PM   = 32'h0a00_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        pwr_failing = 1'b0;
   logic        pf_irq, shutdown_req, reset_req, halt_req;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   logic seen_sd, seen_rs, seen_hl;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwrfail_ctl_regs dut_i (
      .clk          (clk),
      .rst          (rst),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rd       (bus_rd),
      .bus_rdata    (bus_rdata),
      .pwr_failing  (pwr_failing),
      .pf_irq       (pf_irq),
      .shutdown_req (shutdown_req),
      .reset_req    (reset_req),
      .halt_req     (halt_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; pwr_failing = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      seen_sd = shutdown_req; seen_rs = reset_req; seen_hl = halt_req;
   endtask

   task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_pwr(input logic v);
      @(negedge clk);
      pwr_failing = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      apply_reset();
      chk("R1 irq", {31'b0, pf_irq}, 32'h0);
      chk("R1 pulses", {29'b0, shutdown_req, reset_req, halt_req}, 32'h0);
      bus_read(A_CFG, d);  chk("R1 cfg", d, 32'h0);
      bus_read(A_AUXA, d); chk("R1 auxa", d, 32'h0);
      bus_read(A_AUXB, d); chk("R1 auxb", d, 32'h0);
      bus_read(A_DIAG, d); chk("R1 diag", d, 32'h0);
      bus_read(A_MDM, d);  chk("R1 modem", d, 32'h0);
      bus_read(A_SYS, d);  chk("R1 sysctl", d, 32'h0);
   endtask

   task automatic t_byte_regs();
      logic [31:0] d;
      apply_reset();
      bus_write(A_CFG | 32'h0000_1234, 8'hA5);
      bus_write(32'hF190_0000, 8'h3C);
      bus_write(A_DIAG, 8'hFF);
      bus_write(A_MDM | 32'h0000_ffff, 8'h5A);
      bus_read(A_CFG, d);  chk("R2 cfg", d, 32'hA5);
      bus_read(A_AUXA, d); chk("R2 auxa alias", d, 32'h3C);
      bus_read(A_DIAG | 32'h0000_0001, d); chk("R2 diag", d, 32'hFF);
      bus_read(A_MDM, d);  chk("R2 modem", d, 32'h5A);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      apply_reset();
      bus_write(A_AUXA, 8'h11);
      bus_write(32'h0170_0000, 8'hFF);
      bus_write(32'h0192_0000, 8'hEE);
      bus_read(32'h0170_0000, d); chk("R3 unmapped read", d, 32'h0);
      bus_read(A_AUXA, d); chk("R3 auxa untouched", d, 32'h11);
      bus_read(A_AUXB, d); chk("R3 auxb untouched", d, 32'h0);
      bus_read(A_CFG, d);  chk("R3 cfg untouched", d, 32'h0);
   endtask

   task automatic t_pf_input();
      logic [31:0] d;
      apply_reset();
      bus_write(A_CFG, 8'h08);
      set_pwr(1'b1);
      bus_read(A_AUXB, d); chk("R4 set with enable", d, 32'h20);
      set_pwr(1'b0);
      bus_read(A_AUXB, d); chk("R4 clear on fall", d, 32'h0);
      bus_write(A_CFG, 8'h00);
      set_pwr(1'b1);
      bus_read(A_AUXB, d); chk("R4 no set without enable", d, 32'h0);
      bus_write(A_CFG, 8'h08);
      bus_read(A_AUXB, d); chk("R4 no set on enable alone", d, 32'h0);
   endtask

   task automatic t_irq_gate();
      logic [31:0] d;
      apply_reset();
      bus_write(A_CFG, 8'h08);
      chk("R5 irq low before fail", {31'b0, pf_irq}, 32'h0);
      set_pwr(1'b1);
      chk("R5 irq high", {31'b0, pf_irq}, 32'h1);
      bus_write(A_CFG, 8'hF7);
      chk("R5 irq gated off", {31'b0, pf_irq}, 32'h0);
      bus_read(A_AUXB, d); chk("R5 status kept", d, 32'h20);
      bus_write(A_CFG, 8'h08);
      chk("R5 irq back on", {31'b0, pf_irq}, 32'h1);
   endtask

   task automatic t_aux2_write();
      logic [31:0] d;
      apply_reset();
      bus_write(A_CFG, 8'h08);
      set_pwr(1'b1);
      bus_write(A_AUXB, 8'hFC);
      bus_read(A_AUXB, d); chk("R6 status merged", d, 32'h20);
      chk("R6 irq stays", {31'b0, pf_irq}, 32'h1);
      bus_write(A_AUXB, 8'h02);
      bus_read(A_AUXB, d); chk("R6 clear bit", d, 32'h0);
      chk("R6 irq cleared", {31'b0, pf_irq}, 32'h0);
   endtask

   task automatic t_shutdown();
      logic [31:0] d;
      apply_reset();
      bus_write(A_AUXB, 8'h00);
      chk("R7 no pulse on zero", {31'b0, seen_sd}, 32'h0);
      bus_write(A_AUXB, 8'h01);
      chk("R7 pulse", {31'b0, seen_sd}, 32'h1);
      @(negedge clk);
      chk("R7 pulse one cycle", {31'b0, shutdown_req}, 32'h0);
      bus_read(A_AUXB, d); chk("R7 off stored", d, 32'h01);
      bus_write(A_CFG, 8'h08);
      set_pwr(1'b1);
      bus_write(A_AUXB, 8'h03);
      chk("R7 pulse with clear", {31'b0, seen_sd}, 32'h1);
      bus_read(A_AUXB, d); chk("R7 clear keeps off", d, 32'h01);
   endtask

   task automatic t_halt();
      logic [31:0] d;
      apply_reset();
      bus_write(A_CFG, 8'h5A);
      chk("R8 no halt on cfg write", {31'b0, seen_hl}, 32'h0);
      bus_write(A_PM | 32'h0000_0040, 8'hFF);
      chk("R8 halt pulse", {31'b0, seen_hl}, 32'h1);
      @(negedge clk);
      chk("R8 halt one cycle", {31'b0, halt_req}, 32'h0);
      bus_read(A_PM, d);  chk("R8 pm reads zero", d, 32'h0);
      bus_read(A_CFG, d); chk("R8 cfg untouched", d, 32'h5A);
   endtask

   task automatic t_sysctl();
      logic [31:0] d;
      apply_reset();
      bus_write(A_SYS, 8'hFE);
      chk("R9 no reset bit0 clear", {31'b0, seen_rs}, 32'h0);
      bus_read(A_SYS, d); chk("R9 unchanged", d, 32'h0);
      bus_write(A_SYS, 8'h01);
      chk("R9 reset pulse", {31'b0, seen_rs}, 32'h1);
      @(negedge clk);
      chk("R9 pulse one cycle", {31'b0, reset_req}, 32'h0);
      bus_read(A_SYS, d); chk("R9 status value", d, 32'h2);
      bus_write(A_SYS, 8'hFE);
      bus_read(A_SYS, d); chk("R9 held", d, 32'h2);
   endtask

   initial begin
      t_reset();
      t_byte_regs();
      t_unmapped();
      t_pf_input();
      t_irq_gate();
      t_aux2_write();
      t_shutdown();
      t_halt();
      t_sysctl();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=%0d expected=finish", WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule